// File: doc/BRIEF.md
# External Interrupt Polarity Conditioner

This block sits between two external interrupt pins and a parent interrupt controller. The parent only accepts an active-high level or a rising edge. Each pin has its own configuration register on a small memory-mapped write/read port. That register turns the channel on and picks level or edge sensing and the polarity.

Each pin first passes through a two-flop synchronizer. The block then applies the selected sense mode and drives one normalized line per channel. In a level mode the line stays high for as long as the input is in its active state. In an edge mode the line gives a single-cycle high pulse for each qualifying transition. Low-level and falling-edge inputs are therefore inverted on the way out. A disabled channel keeps its line low.

The polarity bit is encoded differently in the two families. For level sensing, a set polarity bit means active-high. For edge sensing, a set polarity bit means falling.

Top module: `ext_irq_cond`

## Requirements
- R1: There are two channels, each with its own bit of `irq_o`. Channel n's configuration register is at byte offset 0x4 + 4*n. Its fields are: bit 16 = enable, bit 9 = level select (1 = level, 0 = edge), bit 8 = polarity.
- R2: A read of a channel register returns the written value masked to bits 16, 9 and 8, with every other bit zero. Offset 0x0 (the global slot) reads zero.
- R3: After reset, both configuration registers read zero and `irq_o` is low.
- R4: While a channel's enable bit is clear, its `irq_o` bit is low from the cycle after the register update on.
- R5: Level-high (bit9=1, bit8=1): `irq_o` is high while the pin is high. A pin change shows at `irq_o` after the third rising clock edge (two synchronizer flops plus one output register).
- R6: Level-low (bit9=1, bit8=0): `irq_o` is high while the pin is low, with the same three-edge latency.
- R7: Rising-edge (bit9=0, bit8=0): each 0-to-1 pin transition yields exactly one cycle of `irq_o` high, three edges after the change. A 1-to-0 transition or a steady pin yields nothing.
- R8: Falling-edge (bit9=0, bit8=1): each 1-to-0 pin transition yields exactly one cycle of `irq_o` high, three edges after the change. A 0-to-1 transition or a steady pin yields nothing.
- R9: Writes are ignored, and leave both channel registers unchanged, in these cases: offset 0x0, offsets past the last channel, and byte offsets that are not word-aligned.
- R10: Rewriting the sense mode or polarity of an enabled channel while its pin is steady produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pin_i | input | 2 | Asynchronous external interrupt pins |
| irq_o | output | 2 | Normalized interrupt lines toward the parent |

## Verification
The bench sweeps both channels over all eight combinations of enable, level select and polarity. For each combination it steps the pin low, high and low again. At each step it checks the output exactly at the three-edge latency point and again one cycle later. This sequence separates the four sense modes from each other, shows that edge pulses last one cycle while level outputs persist, and shows that the idle channel stays quiet. Register patterns with all bits set and with alternating bits check the field mask. Writes to every unmapped or misaligned offset check that such writes are ignored. A series of mode rewrites on a channel that is enabled and has a steady high pin checks that no pulse is created.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int EN_BIT  = 16;
  localparam int LVL_BIT = 9;
  localparam int POL_BIT = 8;
  localparam logic [31:0] CFG_MASK = (32'd1 << EN_BIT) | (32'd1 << LVL_BIT) | (32'd1 << POL_BIT);

  typedef struct packed {
    logic en;
    logic lvl;
    logic pol;
  } ch_cfg_t;
endpackage

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output ch_cfg_t [NUM_CH-1:0] cfg_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic              aligned;
  logic [IDX_W-1:0]  word;
  logic [NUM_CH-1:0] hit;
  ch_cfg_t [NUM_CH-1:0] cfg_q;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign word    = addr_i[ADDR_W-1:2];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    // word 0 is the global slot; channels start at word 1
    assign hit[n] = aligned && (word == IDX_W'(n + 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[n] <= '0;
      else if (wr_en_i && hit[n])
        cfg_q[n] <= '{en: wdata_i[EN_BIT], lvl: wdata_i[LVL_BIT], pol: wdata_i[POL_BIT]};
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (hit[n]) begin
        rdata_o[EN_BIT]  = cfg_q[n].en;
        rdata_o[LVL_BIT] = cfg_q[n].lvl;
        rdata_o[POL_BIT] = cfg_q[n].pol;
      end
    end
  end

  assign cfg_o = cfg_q;

  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~CFG_MASK) == 32'd0);

  // R9
  bad_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !(|hit)) |=> $stable(cfg_q));
endmodule

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/eic_sense.sv
module eic_sense
  import eic_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    s_i,
  input  ch_cfg_t cfg_i,
  output logic    irq_o
);
  logic prev_q, irq_q;
  logic rise, fall, lvl_act, edge_hit, irq_d;

  assign rise     = s_i & ~prev_q;
  assign fall     = ~s_i & prev_q;
  // level: pol=1 active-high, pol=0 active-low
  assign lvl_act  = ~(s_i ^ cfg_i.pol);
  // edge: pol=0 rising, pol=1 falling
  assign edge_hit = cfg_i.pol ? fall : rise;
  assign irq_d    = cfg_i.en & (cfg_i.lvl ? lvl_act : edge_hit);

  // history tracks the raw synced pin every cycle, so a mode rewrite sees prev == s
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= s_i;
      irq_q  <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R4
  dis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |=> !irq_o);

  // R7
  rise_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> !rise);

  // R8
  fall_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> !fall);
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import eic_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NUM_CH-1:0] pin_i,
  output logic [NUM_CH-1:0] irq_o
);
  ch_cfg_t [NUM_CH-1:0] cfg;
  logic    [NUM_CH-1:0] pin_s;

  eic_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .cfg_o   (cfg)
  );

  eic_sync #(.WIDTH(NUM_CH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_sense
    eic_sense u_sense (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .s_i    (pin_s[n]),
      .cfg_i  (cfg[n]),
      .irq_o  (irq_o[n])
    );
  end
endmodule

// File: tb/ext_irq_cond_tb_top.sv
module ext_irq_cond_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  pin = '0;
  logic [1:0]  irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ext_irq_cond dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] mk(bit en, bit lvl, bit pol);
    return ({31'd0, en} << 16) | ({31'd0, lvl} << 9) | ({31'd0, pol} << 8);
  endfunction

  // step pin of channel ch at a negedge, return at the negedge after the third posedge
  task automatic step_pin(int ch, bit v);
    @(negedge clk);
    pin[ch] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R3 reset state
    chk("R3 irq", {30'd0, irq}, 32'd0);
    rd(5'h04, d); chk("R3 ch0", d, 32'd0);
    rd(5'h08, d); chk("R3 ch1", d, 32'd0);

    // R2 readback masking, R1 offsets
    begin
      logic [31:0] pats[4] = '{32'hFFFF_FFFF, 32'h0000_0100, 32'hA5A5_A5A5, 32'h5A5A_5A5A};
      foreach (pats[i]) begin
        wr(5'h04, pats[i]);
        wr(5'h08, ~pats[i]);
        rd(5'h04, d); chk("R2 R1 ch0 readback", d, pats[i] & 32'h0001_0300);
        rd(5'h08, d); chk("R2 R1 ch1 readback", d, ~pats[i] & 32'h0001_0300);
      end
    end
    rd(5'h00, d); chk("R2 global reads zero", d, 32'd0);

    // R9 ignored writes
    wr(5'h04, 32'h0000_0100);
    wr(5'h08, 32'h0001_0200);
    begin
      logic [4:0] bads[7] = '{5'h00, 5'h0C, 5'h10, 5'h1C, 5'h05, 5'h06, 5'h0B};
      foreach (bads[i]) begin
        wr(bads[i], 32'hFFFF_FFFF);
        rd(5'h04, d); chk("R9 ch0 unchanged", d, 32'h0000_0100);
        rd(5'h08, d); chk("R9 ch1 unchanged", d, 32'h0001_0200);
      end
    end
    rd(5'h00, d); chk("R9 global still zero", d, 32'd0);

    // sweep: R4 R5 R6 R7 R8
    wr(5'h04, 32'd0);
    wr(5'h08, 32'd0);
    for (int ch = 0; ch < 2; ch++) begin
      for (int m = 0; m < 8; m++) begin
        bit en, lvl, pol;
        logic [1:0] e;
        en = m[2]; lvl = m[1]; pol = m[0];
        wr(5'(4 + 4 * ch), 32'd0);
        @(negedge clk) pin[ch] = 1'b0;
        repeat (4) @(posedge clk);
        wr(5'(4 + 4 * ch), mk(en, lvl, pol));
        @(posedge clk); @(negedge clk);
        // pin low steady
        e = '0; e[ch] = en & lvl & ~pol;
        chk(lvl ? "R6 R4 steady low" : "R10 R4 edge steady", {30'd0, irq}, {30'd0, e});
        // rise
        step_pin(ch, 1'b1);
        e = '0; e[ch] = en & (lvl ? pol : ~pol);
        chk(lvl ? "R5 R4 level at rise" : "R7 R4 rising pulse", {30'd0, irq}, {30'd0, e});
        @(posedge clk); @(negedge clk);
        e = '0; e[ch] = en & lvl & pol;
        chk(lvl ? "R5 level held high" : "R7 pulse one cycle", {30'd0, irq}, {30'd0, e});
        // fall
        step_pin(ch, 1'b0);
        e = '0; e[ch] = en & (lvl ? ~pol : pol);
        chk(lvl ? "R6 R4 level at fall" : "R8 R4 falling pulse", {30'd0, irq}, {30'd0, e});
        @(posedge clk); @(negedge clk);
        e = '0; e[ch] = en & lvl & ~pol;
        chk(lvl ? "R6 level held low" : "R8 pulse one cycle", {30'd0, irq}, {30'd0, e});
      end
      wr(5'(4 + 4 * ch), 32'd0);
    end

    // R10 mode rewrites with pin steady high
    wr(5'h04, mk(1, 0, 0));
    step_pin(0, 1'b1);
    chk("R10 setup pulse", {30'd0, irq}, 32'd1);
    @(posedge clk); @(negedge clk);
    begin
      logic [31:0] seq[4] = '{mk(1,0,1), mk(1,1,0), mk(1,0,0), mk(1,0,1)};
      foreach (seq[i]) begin
        wr(5'h04, seq[i]);
        chk("R10 write cycle", {30'd0, irq}, 32'd0);
        for (int k = 0; k < 3; k++) begin
          @(posedge clk); @(negedge clk);
          chk("R10 no spurious pulse", {30'd0, irq}, 32'd0);
        end
      end
    end
    // R4 disable while level active
    wr(5'h04, mk(1, 1, 1));
    @(posedge clk); @(negedge clk);
    chk("R5 level active", {30'd0, irq}, 32'd1);
    wr(5'h04, mk(0, 1, 1));
    @(posedge clk); @(negedge clk);
    chk("R4 disabled quiet", {30'd0, irq}, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule